// File: doc/BRIEF.md
# Gated Power-of-Two Clock Divider

The block divides one input clock by two, four and eight at the same time. All three outputs come from a single 3-bit state that is clocked by one internal clock, so an edge common to two or three outputs is produced by the same flop update. This keeps those edges aligned. It is meant for clock trees that need several related rates from one source, or several dividers that must share a phase.

A freeze input stops the divider. The freeze request is captured by a flop clocked on the falling edge of the input clock. The internal clock can therefore be gated only while it is low, and no shortened high pulse can reach the stages. A master reset clears the outputs asynchronously, so that several dividers can be aligned. After reset is released, the first counted rising edge is either the next rising edge or the one after it, depending on the clock level when reset falls.

Top module: `pow2_clk_divider`

## Requirements
- R1: With en and mr low, every rising clk edge adds one, modulo 8, to the 3-bit value {q_div8, q_div4, q_div2}, so q_div2 changes on every rising edge.
- R2: q_div4 changes only on an edge where q_div2 goes from 1 to 0, and q_div8 only on an edge where q_div4 goes from 1 to 0. Over 16 counted edges the outputs q_div2, q_div4 and q_div8 make 16, 8 and 4 transitions, and whenever q_div8 changes, the other two change on the same edge.
- R3: While mr is high, all three outputs are 0. They clear as soon as mr rises, without waiting for a clock edge.
- R4: If en is high at a falling clk edge, the next rising edge leaves all outputs unchanged. This repeats for as long as en stays high.
- R5: Once en is low at a falling edge after a freeze, the next rising edge advances the outputs by one from the held value.
- R6: If mr falls while clk is high, the first rising edge after the release moves the outputs from 000 to 001.
- R7: If mr falls while clk is low, the first rising edge after the release leaves the outputs at 000, and the second moves them to 001.
- R8: A change of en during a low phase of clk has no effect on the rising edge that ends that low phase. The edge counts or holds according to the value of en at the falling edge that started the phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| en | input | 1 | Freeze request, high stops the divider; taken on the falling edge of clk |
| mr | input | 1 | Master reset, active high and asynchronous |
| q_div2 | output | 1 | Input clock divided by two |
| q_div4 | output | 1 | Input clock divided by four |
| q_div8 | output | 1 | Input clock divided by eight |

## Verification
A wrong count state shows on the outputs at the very next counted rising edge, because the outputs are the state bits themselves. A broken carry between stages shows within four edges as a wrong toggle ratio or a misaligned edge. A fault in the freeze flop shows within one clock period. It appears either as an extra advance while frozen, or as a missed advance on the edge after en is seen low at a falling edge. Wrong reset-recovery timing shows on the first or second rising edge after mr falls, depending on the clock phase at release. The stimulus therefore releases mr and toggles en in both clock phases.

// File: rtl/pow2_clk_divider.sv
module pow2_clk_divider (
  input  logic clk,
  input  logic en,
  input  logic mr,
  output logic q_div2,
  output logic q_div4,
  output logic q_div8
);

  logic       hold_q;
  logic       gclk;
  logic [2:0] cnt;

  // Freeze request is taken only while clk falls, so the gate opens and closes in the low phase.
  always_ff @(negedge clk or posedge mr) begin
    if (mr) hold_q <= 1'b1;
    else    hold_q <= en;
  end

  assign gclk = clk & ~hold_q;

  always_ff @(posedge gclk or posedge mr) begin
    if (mr) cnt <= 3'd0;
    else    cnt <= cnt + 3'd1;
  end

  assign {q_div8, q_div4, q_div2} = cnt;

  p_advance_r1: assert property (@(negedge clk) disable iff (mr)
    (!hold_q && !$past(mr)) |-> (cnt == $past(cnt) + 3'd1));

  p_div4_carry_r2: assert property (@(negedge clk) disable iff (mr)
    (!hold_q && !$stable(cnt[1])) |-> ($past(cnt[0]) && !cnt[0]));

  p_div8_carry_r2: assert property (@(negedge clk) disable iff (mr)
    (!hold_q && !$stable(cnt[2])) |-> ($past(cnt[1]) && !cnt[1]));

  p_reset_low_r3: assert property (@(posedge clk)
    mr |-> (cnt == 3'd0));

  p_freeze_r4: assert property (@(negedge clk) disable iff (mr)
    (hold_q && cnt != 3'd0) |-> $stable(cnt));

endmodule

// File: tb/pow2_clk_divider_tb_top.sv
`timescale 1ns/1ps
module pow2_clk_divider_tb_top;

  logic clk = 1'b0;
  logic en  = 1'b0;
  logic mr  = 1'b0;
  logic q_div2, q_div4, q_div8;

  int checks = 0;
  int errors = 0;

  pow2_clk_divider dut_i (
    .clk(clk), .en(en), .mr(mr),
    .q_div2(q_div2), .q_div4(q_div4), .q_div8(q_div8)
  );

  always #10 clk = ~clk;

  // Reference counter model built from the requirements
  logic       ref_gate;
  logic [2:0] ref_cnt;
  always @(negedge clk or posedge mr)
    if (mr) ref_gate <= 1'b1; else ref_gate <= en;
  always @(posedge clk or posedge mr)
    if (mr) ref_cnt <= 3'd0; else if (!ref_gate) ref_cnt <= ref_cnt + 3'd1;

  function automatic logic [2:0] outs();
    return {q_div8, q_div4, q_div2};
  endfunction

  function automatic int bit_flips(logic [2:0] a, logic [2:0] b, int idx);
    return (a[idx] != b[idx]) ? 1 : 0;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // Continuous comparison against the model, 8 ns after every clock edge
  always begin
    @(clk);
    #8;
    check("R1/R2 model", {29'd0, outs()}, {29'd0, ref_cnt});
  end

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    logic [2:0] prev;
    int t2, t4, t8, misalign;
    void'($urandom(32'd20240611));
    #2 mr = 1'b1;
    @(posedge clk); #6;
    check("R3 reset state", {29'd0, outs()}, 32'd0);
    @(posedge clk); #6;

    // R6: release while clk high
    @(posedge clk); #5 mr = 1'b0;
    @(posedge clk); #6;
    check("R6 first edge after high-phase release", {29'd0, outs()}, 32'd1);

    // R1/R2: ratios and alignment over 16 edges
    t2 = 0; t4 = 0; t8 = 0; misalign = 0;
    for (int i = 0; i < 16; i++) begin
      prev = outs();
      @(posedge clk); #6;
      t2 += bit_flips(prev, outs(), 0);
      t4 += bit_flips(prev, outs(), 1);
      t8 += bit_flips(prev, outs(), 2);
      if (bit_flips(prev, outs(), 2) == 1 &&
          (bit_flips(prev, outs(), 1) == 0 || bit_flips(prev, outs(), 0) == 0))
        misalign++;
    end
    check("R1 div2 transitions", t2, 32'd16);
    check("R2 div4 transitions", t4, 32'd8);
    check("R2 div8 transitions", t8, 32'd4);
    check("R2 aligned edges", misalign, 32'd0);
    check("R1 wrap value", {29'd0, outs()}, 32'd1);

    // R3 asynchronous clear, then R7 release while clk low
    @(posedge clk); #5 mr = 1'b1;
    #1 check("R3 clear without edge", {29'd0, outs()}, 32'd0);
    @(negedge clk); #5 mr = 1'b0;
    @(posedge clk); #6;
    check("R7 first edge ignored", {29'd0, outs()}, 32'd0);
    @(posedge clk); #6;
    check("R7 second edge advances", {29'd0, outs()}, 32'd1);

    // R4 freeze, en raised in high phase
    @(posedge clk); #5 en = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #6;
      check("R4 frozen", {29'd0, outs()}, 32'd2);
    end

    // R5 resume, en dropped in high phase
    @(posedge clk); #5 en = 1'b0;
    @(posedge clk); #6;
    check("R5 resume from held value", {29'd0, outs()}, 32'd3);

    // R8 en raised in low phase
    @(negedge clk); #5 en = 1'b1;
    @(posedge clk); #6;
    check("R8 late raise still counts", {29'd0, outs()}, 32'd4);
    @(posedge clk); #6;
    check("R4 frozen after raise", {29'd0, outs()}, 32'd4);

    // R8 en dropped in low phase
    @(negedge clk); #5 en = 1'b0;
    @(posedge clk); #6;
    check("R8 late drop still frozen", {29'd0, outs()}, 32'd4);
    @(posedge clk); #6;
    check("R5 resume after low-phase drop", {29'd0, outs()}, 32'd5);

    // Random phase stimulus, checked by the model comparison
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(1, 0) == 1) @(posedge clk);
      else                            @(negedge clk);
      #5;
      en = ($urandom_range(3, 0) == 0);
      if (mr) mr = ($urandom_range(3, 0) != 0);
      else    mr = ($urandom_range(31, 0) == 0);
    end
    @(negedge clk); #5 mr = 1'b0; en = 1'b0;
    repeat (4) @(posedge clk);
    #6;
    summary();
    $finish;
  end

endmodule